// File: doc/BRIEF.md
# Shared Min/Max Comparator Unit

This unit produces the result of a minimum or maximum operation for a 64-bit integer datapath, as used by atomic read-modify-write sequences and by ALU min/max instructions. It accepts two operands, an operation select (signed or unsigned, minimum or maximum) and a size select (32-bit word or 64-bit doubleword), and returns the chosen operand one clock later, extended to 64 bits in the form in which the datapath stores words.

All four operations at both sizes are served by one magnitude comparator. Word operands are sign-extended to 64 bits before the comparison regardless of signedness; sign extension preserves both the signed and the unsigned ordering of 32-bit values, so a single 64-bit less-than is enough. Signed ordering is obtained by inverting the most significant bit of both comparator inputs. For a maximum the comparator inputs are swapped, so on equal operands the first operand is always the one returned.

A two-state controller (`ST_IDLE`, `ST_EMIT`) tracks whether the output register holds a fresh result. Transitions: `ST_IDLE` to `ST_EMIT` when `in_valid` is high; `ST_EMIT` stays in `ST_EMIT` when `in_valid` is high (back-to-back work); `ST_EMIT` to `ST_IDLE` when `in_valid` is low; `ST_IDLE` stays in `ST_IDLE` when `in_valid` is low. Reset enters `ST_IDLE`.

Top module: `mmx_unit`

## Requirements
- R1: With `size_dw`=1, `op_sel`=2'b00 returns the smaller and `op_sel`=2'b01 the larger of the two operands under two's complement ordering of all 64 bits.
- R2: With `size_dw`=1, `op_sel`=2'b10 returns the smaller and `op_sel`=2'b11 the larger of the two operands under unsigned ordering of all 64 bits.
- R3: With `size_dw`=0 only bits 31:0 of each operand are used; bits 63:32 of the inputs have no effect on the result, and the four operations order the low 32 bits as signed (`op_sel` 2'b00, 2'b01) or unsigned (2'b10, 2'b11) 32-bit values.
- R4: With `size_dw`=0 the result is the chosen operand's bits 31:0 with bit 31 copied into bits 63:32.
- R5: `out_valid` is high in the cycle after every cycle in which `in_valid` was high at a rising clock edge, with `out_result` holding that operation's result.
- R6: After a cycle with `in_valid` low, `out_valid` is low and `out_result` keeps its previous value.
- R7: While `rst_n` is low, `out_valid` and `out_result` are zero.
- R8: Operations presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| op_a | input | 64 | First operand (returned on a tie) |
| op_b | input | 64 | Second operand |
| op_sel | input | 2 | 00 signed min, 01 signed max, 10 unsigned min, 11 unsigned max |
| size_dw | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Selected operand, extended to 64 bits |

## Verification
The hardest situation to reach is a 32-bit operation whose outcome would change if the upper input bits or the sign-extension step were wrong, for example an unsigned word compare of 0x8000_0000 against 0x7FFF_FFFF while bits 63:32 carry conflicting garbage. The stimulus crosses every operation and size with the boundary values 0, 1, all-ones, most negative and most positive at each width, fills the unused upper half of word operands with random bits, and then runs a long seeded random stream of back-to-back and gapped requests checked against a bench model that compares at the operation's own width.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    typedef enum logic [1:0] {
        MM_MIN  = 2'b00,
        MM_MAX  = 2'b01,
        MM_MINU = 2'b10,
        MM_MAXU = 2'b11
    } mm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } mm_state_e;

    // Bit 0 of the op code asks for the larger operand.
    function automatic logic wants_larger(input mm_op_e op);
        return op[0];
    endfunction

    // Bit 1 of the op code selects unsigned ordering.
    function automatic logic wants_signed(input mm_op_e op);
        return ~op[1];
    endfunction

endpackage

// File: rtl/mmx_extend.sv
module mmx_extend #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0] raw,
    input  logic            full,
    output logic [XLEN-1:0] ext
);
    localparam int HI = XLEN - WLEN;

    always_comb begin
        if (full) begin
            ext = raw;
        end else begin
            ext = {{HI{raw[WLEN-1]}}, raw[WLEN-1:0]};
        end
    end
endmodule

// File: rtl/mmx_compare.sv
module mmx_compare #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic            signed_mode,
    output logic            lt
);
    logic [XLEN-1:0] lhs_k;
    logic [XLEN-1:0] rhs_k;

    // Inverting the top bit of both sides maps two's complement order
    // onto unsigned order, so one unsigned less-than serves both modes.
    always_comb begin
        lhs_k = lhs;
        rhs_k = rhs;
        lhs_k[XLEN-1] = lhs[XLEN-1] ^ signed_mode;
        rhs_k[XLEN-1] = rhs[XLEN-1] ^ signed_mode;
        lt = lhs_k < rhs_k;
    end
endmodule

// File: rtl/mmx_unit.sv
module mmx_unit #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [1:0]      op_sel,
    input  logic            size_dw,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    import mmx_pkg::*;

    localparam int NOPS = 2;

    mm_op_e          op;
    logic [XLEN-1:0] raw   [NOPS];
    logic [XLEN-1:0] wide  [NOPS];
    logic [XLEN-1:0] cmp_l;
    logic [XLEN-1:0] cmp_r;
    logic            cmp_lt;
    logic            take_b;
    logic [XLEN-1:0] pick_raw;
    logic [XLEN-1:0] pick_ext;
    mm_state_e       state_q;
    mm_state_e       state_d;
    logic [XLEN-1:0] result_q;

    assign op     = mm_op_e'(op_sel);
    assign raw[0] = op_a;
    assign raw[1] = op_b;

    // Operand widening: word operands are sign-extended for every op.
    for (genvar i = 0; i < NOPS; i++) begin : g_widen
        mmx_extend #(.XLEN(XLEN), .WLEN(WLEN)) u_ext (
            .raw (raw[i]),
            .full(size_dw),
            .ext (wide[i])
        );
    end

    // Steering: min asks "b < a", max asks "a < b"; a tie keeps op_a.
    always_comb begin
        if (wants_larger(op)) begin
            cmp_l = wide[0];
            cmp_r = wide[1];
        end else begin
            cmp_l = wide[1];
            cmp_r = wide[0];
        end
    end

    mmx_compare #(.XLEN(XLEN)) u_cmp (
        .lhs        (cmp_l),
        .rhs        (cmp_r),
        .signed_mode(wants_signed(op)),
        .lt         (cmp_lt)
    );

    assign take_b   = cmp_lt;
    assign pick_raw = take_b ? op_b : op_a;

    // Store-side extension of the chosen operand's low bits.
    mmx_extend #(.XLEN(XLEN), .WLEN(WLEN)) u_store_ext (
        .raw (pick_raw),
        .full(size_dw),
        .ext (pick_ext)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register, loaded only by an accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= pick_ext;
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
        out_result = result_q;
    end
endmodule

// File: rtl/mmx_checker.sv
module mmx_checker #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic [1:0]      op_sel,
    input logic            size_dw,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R6

    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(size_dw)) |->
        out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}); // R4

    AST_SMIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size_dw) && $past(op_sel) == 2'b00) |->
        ($signed(out_result) <= $signed($past(op_a)) &&
         $signed(out_result) <= $signed($past(op_b)))); // R1

    AST_SMAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size_dw) && $past(op_sel) == 2'b01) |->
        ($signed(out_result) >= $signed($past(op_a)) &&
         $signed(out_result) >= $signed($past(op_b)))); // R1

    AST_UMIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size_dw) && $past(op_sel) == 2'b10) |->
        (out_result <= $past(op_a) && out_result <= $past(op_b))); // R2

    AST_UMAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size_dw) && $past(op_sel) == 2'b11) |->
        (out_result >= $past(op_a) && out_result >= $past(op_b))); // R2

    AST_WORD_FROM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(size_dw)) |->
        (out_result[WLEN-1:0] == $past(op_a[WLEN-1:0]) ||
         out_result[WLEN-1:0] == $past(op_b[WLEN-1:0]))); // R3

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && out_result == '0); // R7
        end
    end
endmodule

bind mmx_unit mmx_checker #(.XLEN(XLEN), .WLEN(WLEN)) u_mmx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .size_dw   (size_dw),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/mmx_unit_tb.sv
module mmx_unit_tb;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [63:0]     op_a = '0;
    logic [63:0]     op_b = '0;
    logic [1:0]      op_sel = '0;
    logic            size_dw = 1'b0;
    logic            out_valid;
    logic [63:0]     out_result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        pend = 1'b0;
    logic [63:0] pend_exp = '0;
    logic [63:0] last_exp = '0;

    always #4 clk = ~clk;

    mmx_unit #(.XLEN(XLEN), .WLEN(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .size_dw(size_dw),
        .out_valid(out_valid), .out_result(out_result)
    );

    // Reference model: compare at the operation's own width.
    function automatic logic [63:0] ref_mm(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] sel, input logic dw);
        logic b_below, a_below, take_b;
        logic [63:0] pick;
        if (dw) begin
            b_below = sel[1] ? (b < a) : ($signed(b) < $signed(a));
            a_below = sel[1] ? (a < b) : ($signed(a) < $signed(b));
        end else begin
            b_below = sel[1] ? (b[31:0] < a[31:0]) : ($signed(b[31:0]) < $signed(a[31:0]));
            a_below = sel[1] ? (a[31:0] < b[31:0]) : ($signed(a[31:0]) < $signed(b[31:0]));
        end
        take_b = sel[0] ? a_below : b_below;
        pick = take_b ? b : a;
        return dw ? pick : {{32{pick[31]}}, pick[31:0]};
    endfunction

    function automatic string tag_of(input logic [1:0] sel, input logic dw);
        if (!dw) return "R3/R4";
        return sel[1] ? "R2" : "R1";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: check the previous request, then present a new one.
    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] sel, input logic dw, input string req);
        if (pend) begin
            check({"R5/R8 ", req, " valid"}, {63'd0, out_valid}, 64'd1);
            check({"R5 ", req}, out_result, pend_exp);
        end else begin
            check("R6 idle valid", {63'd0, out_valid}, 64'd0);
            check("R6 held result", out_result, last_exp);
        end
        in_valid = v; op_a = a; op_b = b; op_sel = sel; size_dw = dw;
        pend = v;
        if (v) begin
            pend_exp = ref_mm(a, b, sel, dw);
            last_exp = pend_exp;
        end
        @(negedge clk);
    endtask

    function automatic logic [63:0] bval(input int k, input logic dw);
        logic [63:0] v;
        unique case (k)
            0: v = 64'd0;
            1: v = 64'd1;
            2: v = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
            3: v = dw ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
            default: v = dw ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        endcase
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] ga, gb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset valid", {63'd0, out_valid}, 64'd0);
        check("R7 reset result", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed boundary crossing, back to back (R1, R2, R3, R4, R8).
        for (int dw = 0; dw < 2; dw++) begin
            for (int s = 0; s < 4; s++) begin
                for (int i = 0; i < 5; i++) begin
                    for (int j = 0; j < 5; j++) begin
                        ga = bval(i, dw[0]);
                        gb = bval(j, dw[0]);
                        if (dw == 0) begin
                            ga[63:32] = $urandom;
                            gb[63:32] = $urandom;
                        end
                        step(1'b1, ga, gb, s[1:0], dw[0], tag_of(s[1:0], dw[0]));
                    end
                end
            end
        end

        // R3: upper halves that disagree with the low halves.
        step(1'b1, 64'h7FFF_FFFF_8000_0000, 64'h8000_0000_7FFF_FFFF, 2'b10, 1'b0, "R3 umin word");
        step(1'b1, 64'h7FFF_FFFF_8000_0000, 64'h8000_0000_7FFF_FFFF, 2'b00, 1'b0, "R3 smin word");
        step(1'b1, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_FFFF_FFFF, 2'b11, 1'b0, "R3/R4 umax word");
        // R6: gap then idle hold.
        step(1'b0, 64'hDEAD, 64'hBEEF, 2'b01, 1'b1, "R6 gap");
        step(1'b0, 64'h1234, 64'h5678, 2'b11, 1'b0, "R6 gap");

        // Random stream with gaps.
        for (int n = 0; n < 2000; n++) begin
            logic v;
            logic [1:0] s;
            logic d;
            v = ($urandom % 4) != 0;
            s = 2'($urandom);
            d = 1'($urandom);
            ga = {$urandom, $urandom};
            gb = ($urandom % 8 == 0) ? ga : {$urandom, $urandom};
            if ($urandom % 4 == 0) gb[63] = ~ga[63];
            step(v, ga, gb, s, d, tag_of(s, d));
        end
        step(1'b0, '0, '0, 2'b00, 1'b0, "R6 drain");
        step(1'b0, '0, '0, 2'b00, 1'b0, "R6 drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule